// File: doc/BRIEF.md
# Dual-Role Test Register: Pattern Source and Parallel Response Compactor

This block is a three-stage test register for built-in self-test. Depending on a two-bit mode input, it acts as an ordinary parallel-load register, clears itself, runs free as a maximal-length pseudo-random pattern source, or folds a parallel response word into a running signature on every clock. Both test roles run on the same internal-XOR (type 2) shift structure. Its feedback follows the reciprocal primitive polynomial 1 + x^2 + x^3. Stage 0 takes the feedback bit. Stage 1 takes stage 0. Stage 2 takes stage 1 XOR the feedback bit. The feedback bit is the current stage 2.

In compaction mode, each stage also XORs in one bit of the response word. In this way several response streams are compressed at once, which saves the cost of a serial signature register per output. The `NUM_INPUTS` parameter (2 or 3) says how many response bits are in use. When it is 2, the input XOR at stage 2 is not built, and bit 2 of the response word has no effect on the signature. In pattern mode, an all-zero state is forced to 001 so that the generator cannot lock up.

Top module: `bilbo_sig_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 000 at that edge, whatever the mode.
- R2: Mode 2'b00 (parallel load): the state takes all three bits of `resp_in` at the next edge.
- R3: Mode 2'b01 (clear): the state becomes 000 at the next edge.
- R4: Mode 2'b10 (pattern), from a non-zero state s = {s2,s1,s0}: the next state is {s1^s2, s0, s2}. `resp_in` has no effect.
- R5: Mode 2'b10, from state 000: the next state is 001.
- R6: In mode 2'b10, starting from 001, the state passes 001,010,100,101,111,011,110. It returns to 001 after exactly 7 edges and never reaches 000.
- R7: Mode 2'b11 (compaction): the next state is {s1^s2^r2, s0^r1, s2^r0}, where r = `resp_in`. The term r2 is present only when `NUM_INPUTS` is 3.
- R8: With `NUM_INPUTS` = 2 in mode 2'b11, `resp_in[2]` has no effect on the state.
- R9: In mode 2'b11 with `resp_in` = 000, the state follows the plain shift of R4. A state of 000 therefore stays 000, with no lockup escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 load, 01 clear, 10 pattern, 11 compaction |
| resp_in | input | 3 | Parallel response word / load data |
| state_q | output | 3 | Register state (pattern or signature) |

## Verification
The bench builds two copies of the block side by side from one set of stimulus. One copy has `NUM_INPUTS` = 3 and the other has `NUM_INPUTS` = 2. Each copy is compared every cycle against a bit-level reference model of the stepping rules. Because both copies receive the same stimulus, a word that differs only in bit 2 must change the three-input signature and leave the two-input signature untouched. The pattern-mode walk checks the full seven-state cycle and the escape from 000 on both widths.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    localparam int STATE_W = 3;
    // Stages that receive the feedback bit through an internal XOR (stage 0 gets it directly)
    localparam logic [STATE_W-1:0] TAP_MASK = 3'b100;
    localparam logic [STATE_W-1:0] LOCKUP_SEED = 3'b001;

    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic [1:0] {
        MODE_LOAD  = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_PRPG  = 2'b10,
        MODE_MISR  = 2'b11
    } mode_e;

    typedef struct packed {
        state_t plain;
        logic   is_zero;
    } step_t;

    function automatic state_t galois_step(state_t s);
        logic   fb;
        state_t n;
        fb = s[STATE_W-1];
        n  = {s[STATE_W-2:0], fb};
        return n ^ (TAP_MASK & {STATE_W{fb}});
    endfunction

endpackage

// File: rtl/bilbo_shift_core.sv
module bilbo_shift_core
    import bilbo_pkg::*;
(
    input  state_t cur,
    output step_t  step
);
    state_t shifted;

    always_comb begin
        shifted = galois_step(cur);
    end

    assign step.plain   = shifted;
    assign step.is_zero = (cur == '0);

endmodule

// File: rtl/bilbo_input_gate.sv
module bilbo_input_gate
    import bilbo_pkg::*;
#(
    parameter int NUM_INPUTS = 3
) (
    input  state_t resp,
    output state_t gated
);
    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        if (i < NUM_INPUTS) begin : g_used
            assign gated[i] = resp[i];
        end else begin : g_unused
            assign gated[i] = 1'b0;
        end
    end

endmodule

// File: rtl/bilbo_next_sel.sv
module bilbo_next_sel
    import bilbo_pkg::*;
(
    input  mode_e  mode,
    input  state_t load_data,
    input  state_t gated,
    input  step_t  step,
    output state_t nxt
);
    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt = load_data;
            MODE_CLEAR: nxt = '0;
            MODE_PRPG:  nxt = step.is_zero ? LOCKUP_SEED : step.plain;
            MODE_MISR:  nxt = step.plain ^ gated;
            default:    nxt = '0;
        endcase
    end

endmodule

// File: rtl/bilbo_sig_reg.sv
module bilbo_sig_reg
    import bilbo_pkg::*;
#(
    parameter int NUM_INPUTS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic [2:0] resp_in,
    output logic [2:0] state_q
);
    mode_e  mode_s;
    state_t cur_q;
    state_t gated;
    state_t nxt;
    step_t  step;

    assign mode_s = mode_e'(mode);

    bilbo_shift_core u_core (
        .cur  (cur_q),
        .step (step)
    );

    bilbo_input_gate #(
        .NUM_INPUTS (NUM_INPUTS)
    ) u_gate (
        .resp  (resp_in),
        .gated (gated)
    );

    bilbo_next_sel u_sel (
        .mode      (mode_s),
        .load_data (resp_in),
        .gated     (gated),
        .step      (step),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign state_q = cur_q;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (state_q == $past(resp_in)));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (state_q == 3'b000));

    // R5
    lockup_escape_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && state_q == 3'b000) |=> (state_q == 3'b001));

    // R4
    prpg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (state_q != 3'b000));

    // R9
    misr_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && resp_in == 3'b000 && state_q == 3'b000) |=> (state_q == 3'b000));

endmodule

// File: tb/sim_bilbo_sig_reg.sv
`timescale 1ns/1ps
module sim_bilbo_sig_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b01;
    logic [2:0] resp_in = 3'b000;
    logic [2:0] q3, q2;
    logic [2:0] m3, m2;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bilbo_sig_reg #(.NUM_INPUTS(3)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .resp_in(resp_in), .state_q(q3));
    bilbo_sig_reg #(.NUM_INPUTS(2)) u1 (
        .clk(clk), .rst(rst), .mode(mode), .resp_in(resp_in), .state_q(q2));

    function automatic logic [2:0] ref_next(input logic [1:0] md, input logic [2:0] s,
                                            input logic [2:0] r, input int ni);
        logic [2:0] p;
        logic [2:0] rr;
        p  = {s[1] ^ s[2], s[0], s[2]};
        rr = (ni == 3) ? r : {1'b0, r[1:0]};
        case (md)
            2'b00:   return r;
            2'b01:   return 3'b000;
            2'b10:   return (s == 3'b000) ? 3'b001 : p;
            default: return p ^ rr;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // apply inputs just after an edge, clock once, compare both copies against the model
    task automatic tick(input string req, input logic [1:0] md, input logic [2:0] r);
        mode = md;
        resp_in = r;
        m3 = ref_next(md, m3, r, 3);
        m2 = ref_next(md, m2, r, 2);
        @(posedge clk); #1;
        check({req, " n3"}, q3, m3);
        check({req, " n2"}, q2, m2);
    endtask

    task automatic test_reset();
        rst = 1'b1; mode = 2'b00; resp_in = 3'b111;
        @(posedge clk); #1;
        m3 = 3'b000; m2 = 3'b000;
        check("R1 reset n3", q3, 3'b000);
        check("R1 reset n2", q2, 3'b000);
        rst = 1'b0;
    endtask

    task automatic test_load();
        tick("R2 load", 2'b00, 3'b101);
        tick("R2 load", 2'b00, 3'b110);
        tick("R2 load", 2'b00, 3'b111);
    endtask

    task automatic test_clear();
        tick("R2 load", 2'b00, 3'b011);
        tick("R3 clear", 2'b01, 3'b111);
        check("R3 clear value", q3, 3'b000);
    endtask

    task automatic test_prpg_cycle();
        logic [2:0] seq [7] = '{3'b010, 3'b100, 3'b101, 3'b111, 3'b011, 3'b110, 3'b001};
        tick("R3 clear", 2'b01, 3'b000);
        tick("R5 lockup escape", 2'b10, 3'b000);
        check("R5 escape value", q3, 3'b001);
        for (int k = 0; k < 7; k++) begin
            tick("R4 prpg step", 2'b10, 3'b000);
            check("R6 sequence n3", q3, seq[k]);
            check("R6 sequence n2", q2, seq[k]);
            if (k < 6 && q3 == 3'b001) check("R6 early return", q3, seq[k]);
        end
    endtask

    task automatic test_prpg_ignore();
        tick("R2 load", 2'b00, 3'b100);
        tick("R4 prpg ignores resp", 2'b10, 3'b111);
        check("R4 value", q3, 3'b101);
        tick("R4 prpg ignores resp", 2'b10, 3'b010);
        check("R4 value", q3, 3'b111);
    endtask

    task automatic test_misr();
        logic [2:0] vec [6] = '{3'b001, 3'b110, 3'b111, 3'b010, 3'b101, 3'b011};
        tick("R3 clear", 2'b01, 3'b000);
        for (int k = 0; k < 6; k++) tick("R7 compaction", 2'b11, vec[k]);
    endtask

    task automatic test_mask();
        tick("R2 load", 2'b00, 3'b011);
        tick("R8 bit2 only", 2'b11, 3'b100);
        check("R8 n2 unaffected", q2, 3'b110);
        check("R7 n3 bit2 folded", q3, 3'b010);
    endtask

    task automatic test_misr_zero();
        tick("R3 clear", 2'b01, 3'b000);
        tick("R9 zero holds", 2'b11, 3'b000);
        check("R9 stays zero", q3, 3'b000);
        tick("R2 load", 2'b00, 3'b100);
        tick("R9 plain shift", 2'b11, 3'b000);
        check("R9 plain value", q3, 3'b101);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m3 = 3'b000; m2 = 3'b000;
        @(posedge clk); #1;
        test_reset();
        test_load();
        test_clear();
        test_prpg_cycle();
        test_prpg_ignore();
        test_misr();
        test_mask();
        test_misr_zero();
        mode = 2'b00; resp_in = 3'b111;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset over load n3", q3, 3'b000);
        check("R1 reset over load n2", q2, 3'b000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule